// File: doc/BRIEF.md
# SPI NAND Operation Sequencer

This block turns one host request into the full series of SPI NAND command frames that the request needs. It handles three operations: a block erase, a page read, and a page program. A page read loads the array into the device cache and then streams the cache out. A page program fills the cache from the host and then commits it to the array. The host supplies an operation code, a row address (page or block), a column offset, a byte count and, for programs, a byte stream. The sequencer returns a one-cycle completion pulse, a pass/fail flag and, for reads, the page bytes in order.

Below the sequencer sits a byte-level SPI master, seen here only as a request/acknowledge handshake that moves one byte in each direction per acknowledge. The sequencer frames every command with chip select. After any operation that leaves the device busy, it polls the device status register until the busy bit clears. It then judges the final status in the way that suits the operation.

Top module: `nand_op_seq`

## Requirements
- R1: A request is accepted only while `busy` is low and `req_op` is 0 (read), 1 (program) or 2 (erase); code 3 is ignored. `busy` rises in the cycle after acceptance and stays high through the single cycle in which `done` is high. It falls in the cycle after that.
- R2: An erase sends a one-byte frame 0x06, then a frame of 0xD8 followed by the 24-bit row MSB first, with its low log2(64)=6 bits cleared. It then polls status.
- R3: A status poll is a frame of 0x0F, 0xC0 and one received byte. Polls repeat while bit 0 of that byte is 1 and stop at the first byte with bit 0 clear.
- R4: A read sends 0x13 with the 24-bit row MSB first and polls. It then sends 0x03, the 16-bit column MSB first, one dummy byte and `len` data bytes. Each received data byte appears on `rd_data` with a one-cycle `rd_valid`, in order.
- R5: A program sends 0x06, then 0x84 with the 16-bit column MSB first and `len` bytes taken from `wr_data`, one per `wr_take` pulse. It then sends 0x10 with the 24-bit row MSB first, and polls.
- R6: `fail` is judged on the final status byte: bit 2 for an erase, bit 3 for a program, and bits [5:4] equal to 2'b10 for a read. A failed read issues no 0x03 frame. `fail` is valid while `done` is high and holds until the next acceptance.
- R7: `spi_cs_n` is low for the whole of each frame and `xfer_req` is high only while it is low. Between two frames `spi_cs_n` stays high for at least one cycle.
- R8: While idle, no frame is sent and `spi_cs_n` is high.
- R9: A request that arrives while busy is not taken. A request held high across the `done` cycle is accepted once, after `busy` falls.
- R10: After reset, `busy`, `done`, `fail`, `xfer_req`, `wr_take` and `rd_valid` are low and `spi_cs_n` is high.
- R11: A read or program with `len` equal to 0 sends no data bytes. The read's 0x03 frame is then 4 bytes long and the program's 0x84 frame 3 bytes long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 erase |
| req_row | input | 24 | Page address (block address for erase) |
| req_col | input | 16 | Column offset within the page |
| req_len | input | 12 | Number of data bytes |
| wr_data | input | 8 | Current host byte for a program |
| wr_take | output | 1 | Current `wr_data` byte consumed |
| rd_valid | output | 1 | `rd_data` holds a page byte |
| rd_data | output | 8 | Page byte read from the cache |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the finished operation |
| spi_cs_n | output | 1 | Active-low chip select |
| xfer_req | output | 1 | Byte transfer request to the SPI master |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Byte transfer finished |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_ack` |

## Verification
The completion of one operation and the acceptance of the next can meet in the same cycle. The bench provokes this by raising a program request right after an erase starts and holding it through the erase's `done` cycle. It then judges the frame log: the erase frames must be complete and undisturbed, and the program frames must follow them exactly once. A second collision is inside the status judgement. Random final status bytes set the fail bits of other operations at the same time as the bit that matters, and the expected `fail` uses only the bit that belongs to the running operation.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the SPI NAND operation sequencer.
// Assumes a device with a single status register read through one address byte.
package nseq_pkg;
    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_PROG  = 2'd1;
    localparam logic [1:0] OP_ERASE = 2'd2;

    localparam logic [7:0] CMD_WREN     = 8'h06;
    localparam logic [7:0] CMD_ERASE    = 8'hD8;
    localparam logic [7:0] CMD_LOAD     = 8'h13;
    localparam logic [7:0] CMD_CACHE_RD = 8'h03;
    localparam logic [7:0] CMD_CACHE_WR = 8'h84;
    localparam logic [7:0] CMD_EXEC     = 8'h10;
    localparam logic [7:0] CMD_GETSTAT  = 8'h0F;
    localparam logic [7:0] STAT_REG_SEL = 8'hC0;

    localparam int         ST_BUSY_BIT  = 0;
    localparam int         ST_EFAIL_BIT = 2;
    localparam int         ST_PFAIL_BIT = 3;
    localparam logic [1:0] ECC_UNCORR   = 2'b10;

    typedef enum logic [1:0] {
        DM_NONE,
        DM_WRITE,
        DM_READ,
        DM_STAT
    } dmode_e;
endpackage

// File: rtl/nseq_status_eval.sv
`timescale 1ns/1ps
// Judges a polled status byte for the operation in progress.
// Assumes the byte is stable while the result is used.
module nseq_status_eval
    import nseq_pkg::*;
(
    input  logic [7:0] stat,
    input  logic [1:0] op,
    output logic       dev_busy,
    output logic       op_fail
);
    logic unused_stat_bits;

    assign unused_stat_bits = ^{stat[7:6], stat[1]};
    assign dev_busy = stat[ST_BUSY_BIT];

    // Choose the failure indication that belongs to the running operation.
    always_comb begin
        case (op)
            OP_ERASE: op_fail = stat[ST_EFAIL_BIT];
            OP_PROG:  op_fail = stat[ST_PFAIL_BIT];
            default:  op_fail = (stat[5:4] == ECC_UNCORR);
        endcase
    end
endmodule

// File: rtl/nseq_cmd_engine.sv
`timescale 1ns/1ps
// Runs one chip-select framed command: opcode, address bytes MSB first,
// optional dummy byte, then an optional data phase (host write, host read
// or a single status byte). Ends each frame with one deselected cycle.
// Assumes start is only given while the engine is idle.
module nseq_cmd_engine
    import nseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 12,
    parameter int AB_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AB_W-1:0]   addr_nb,
    input  logic              dummy,
    input  dmode_e            dmode,
    input  logic [LEN_W-1:0]  dlen,
    output logic              cmd_done,
    output logic [7:0]        stat_q,
    input  logic [7:0]        wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              cs_n,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx
);
    typedef enum logic [2:0] {E_IDLE, E_OPC, E_ADDR, E_DUM, E_DATA, E_GAP} est_e;

    est_e              st;
    est_e              after_addr;
    est_e              after_dum;
    logic [7:0]        opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [AB_W-1:0]   anb_q;
    logic [AB_W-1:0]   acnt;
    logic              dum_q;
    dmode_e            dm_q;
    logic [LEN_W-1:0]  dcnt;

    // Work out which phase follows the address and the dummy byte.
    always_comb begin
        after_dum  = (dm_q != DM_NONE && dcnt != '0) ? E_DATA : E_GAP;
        after_addr = dum_q ? E_DUM : after_dum;
    end

    // Phase sequencing and latching of the command parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            opc_q  <= '0;
            addr_q <= '0;
            anb_q  <= '0;
            acnt   <= '0;
            dum_q  <= 1'b0;
            dm_q   <= DM_NONE;
            dcnt   <= '0;
            stat_q <= '0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    opc_q  <= opcode;
                    addr_q <= addr;
                    anb_q  <= addr_nb;
                    dum_q  <= dummy;
                    dm_q   <= dmode;
                    dcnt   <= dlen;
                    st     <= E_OPC;
                end
                E_OPC: if (xfer_ack) begin
                    acnt <= anb_q - AB_W'(1);
                    st   <= (anb_q != '0) ? E_ADDR : after_addr;
                end
                E_ADDR: if (xfer_ack) begin
                    if (acnt == '0) st <= after_addr;
                    else            acnt <= acnt - AB_W'(1);
                end
                E_DUM: if (xfer_ack) st <= after_dum;
                E_DATA: if (xfer_ack) begin
                    if (dm_q == DM_STAT) stat_q <= xfer_rx;
                    dcnt <= dcnt - LEN_W'(1);
                    if (dcnt == LEN_W'(1)) st <= E_GAP;
                end
                E_GAP:   st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    // Byte to shift out in the current phase.
    always_comb begin
        case (st)
            E_OPC:   xfer_tx = opc_q;
            E_ADDR:  xfer_tx = addr_q[{acnt, 3'b000} +: 8];
            E_DATA:  xfer_tx = (dm_q == DM_WRITE) ? wr_data : 8'h00;
            default: xfer_tx = 8'h00;
        endcase
    end

    assign cs_n     = (st == E_IDLE) || (st == E_GAP);
    assign xfer_req = !cs_n;
    assign cmd_done = (st == E_GAP);
    assign wr_take  = (st == E_DATA) && (dm_q == DM_WRITE) && xfer_ack;
    assign rd_valid = (st == E_DATA) && (dm_q == DM_READ) && xfer_ack;
    assign rd_data  = xfer_rx;
endmodule

// File: rtl/nand_op_seq.sv
`timescale 1ns/1ps
// Top of the SPI NAND operation sequencer. Accepts one host request while
// idle and walks it through write-enable, main command, execute, status
// polling and cache read steps, each issued through the command engine.
// Assumes the SPI master acknowledges every requested byte eventually.
module nand_op_seq
    import nseq_pkg::*;
#(
    parameter int ROW_W         = 24,
    parameter int COL_W         = 16,
    parameter int LEN_W         = 12,
    parameter int PAGES_PER_BLK = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             spi_cs_n,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_ack,
    input  logic [7:0]       xfer_rx
);
    localparam int BLK_SH = $clog2(PAGES_PER_BLK);
    localparam int ROW_NB = ROW_W / 8;
    localparam int COL_NB = COL_W / 8;
    localparam int AB_W   = $clog2(ROW_NB + 1);

    typedef enum logic [2:0] {T_IDLE, T_WREN, T_MAIN, T_EXEC, T_POLL, T_CACHE, T_FIN} tst_e;

    tst_e             st;
    logic [1:0]       op_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] len_q;
    logic             launched;
    logic             fail_q;
    logic             accept;

    logic             cmd_start;
    logic             cmd_done;
    logic [7:0]       cmd_opc;
    logic [ROW_W-1:0] cmd_addr;
    logic [AB_W-1:0]  cmd_nb;
    logic             cmd_dum;
    dmode_e           cmd_dm;
    logic [LEN_W-1:0] cmd_len;
    logic [7:0]       stat_q;
    logic             dev_busy;
    logic             op_fail;
    logic [ROW_W-1:0] col_ext;
    logic [ROW_W-1:0] blk_row;

    assign accept  = (st == T_IDLE) && req_valid && (req_op != 2'd3);
    assign col_ext = {{(ROW_W-COL_W){1'b0}}, col_q};
    assign blk_row = {row_q[ROW_W-1:BLK_SH], {BLK_SH{1'b0}}};

    // Operation-level step sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= T_IDLE;
            op_q     <= OP_READ;
            row_q    <= '0;
            col_q    <= '0;
            len_q    <= '0;
            launched <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            if (cmd_start) launched <= 1'b1;
            if (cmd_done)  launched <= 1'b0;
            case (st)
                T_IDLE: if (accept) begin
                    op_q   <= req_op;
                    row_q  <= req_row;
                    col_q  <= req_col;
                    len_q  <= req_len;
                    fail_q <= 1'b0;
                    st     <= (req_op == OP_READ) ? T_MAIN : T_WREN;
                end
                T_WREN: if (cmd_done) st <= T_MAIN;
                T_MAIN: if (cmd_done) st <= (op_q == OP_PROG) ? T_EXEC : T_POLL;
                T_EXEC: if (cmd_done) st <= T_POLL;
                T_POLL: if (cmd_done && !dev_busy) begin
                    if (op_q == OP_READ && !op_fail) begin
                        st <= T_CACHE;
                    end else begin
                        fail_q <= op_fail;
                        st     <= T_FIN;
                    end
                end
                T_CACHE: if (cmd_done) st <= T_FIN;
                T_FIN:   st <= T_IDLE;
                default: st <= T_IDLE;
            endcase
        end
    end

    // Parameters of the command frame that belongs to the current step.
    always_comb begin
        cmd_opc  = CMD_WREN;
        cmd_addr = '0;
        cmd_nb   = '0;
        cmd_dum  = 1'b0;
        cmd_dm   = DM_NONE;
        cmd_len  = '0;
        case (st)
            T_MAIN: begin
                if (op_q == OP_PROG) begin
                    cmd_opc  = CMD_CACHE_WR;
                    cmd_addr = col_ext;
                    cmd_nb   = AB_W'(COL_NB);
                    cmd_dm   = DM_WRITE;
                    cmd_len  = len_q;
                end else begin
                    cmd_opc  = (op_q == OP_ERASE) ? CMD_ERASE : CMD_LOAD;
                    cmd_addr = (op_q == OP_ERASE) ? blk_row : row_q;
                    cmd_nb   = AB_W'(ROW_NB);
                end
            end
            T_EXEC: begin
                cmd_opc  = CMD_EXEC;
                cmd_addr = row_q;
                cmd_nb   = AB_W'(ROW_NB);
            end
            T_POLL: begin
                cmd_opc  = CMD_GETSTAT;
                cmd_addr = {{(ROW_W-8){1'b0}}, STAT_REG_SEL};
                cmd_nb   = AB_W'(1);
                cmd_dm   = DM_STAT;
                cmd_len  = LEN_W'(1);
            end
            T_CACHE: begin
                cmd_opc  = CMD_CACHE_RD;
                cmd_addr = col_ext;
                cmd_nb   = AB_W'(COL_NB);
                cmd_dum  = 1'b1;
                cmd_dm   = DM_READ;
                cmd_len  = len_q;
            end
            default: ;
        endcase
    end

    assign cmd_start = !launched && (st != T_IDLE) && (st != T_FIN);

    nseq_cmd_engine #(
        .ADDR_W (ROW_W),
        .LEN_W  (LEN_W),
        .AB_W   (AB_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_start),
        .opcode   (cmd_opc),
        .addr     (cmd_addr),
        .addr_nb  (cmd_nb),
        .dummy    (cmd_dum),
        .dmode    (cmd_dm),
        .dlen     (cmd_len),
        .cmd_done (cmd_done),
        .stat_q   (stat_q),
        .wr_data  (wr_data),
        .wr_take  (wr_take),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .cs_n     (spi_cs_n),
        .xfer_req (xfer_req),
        .xfer_tx  (xfer_tx),
        .xfer_ack (xfer_ack),
        .xfer_rx  (xfer_rx)
    );

    nseq_status_eval u_eval (
        .stat     (stat_q),
        .op       (op_q),
        .dev_busy (dev_busy),
        .op_fail  (op_fail)
    );

    assign busy = (st != T_IDLE);
    assign done = (st == T_FIN);
    assign fail = fail_q;
endmodule

// File: rtl/nand_op_seq_chk.sv
`timescale 1ns/1ps
// Temporal checks on the sequencer's ports, attached through bind.
module nand_op_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic xfer_req,
    input logic xfer_ack,
    input logic wr_take,
    input logic rd_valid
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R1
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R1
    AST_BUSY_END_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done)); // R1
    AST_REQ_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> !spi_cs_n); // R7
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_cs_n) |=> spi_cs_n); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> spi_cs_n); // R8
    AST_TAKE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) wr_take |-> (xfer_ack && !rd_valid)); // R5
    AST_READ_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> xfer_ack); // R4
endmodule

bind nand_op_seq nand_op_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .xfer_req (xfer_req),
    .xfer_ack (xfer_ack),
    .wr_take  (wr_take),
    .rd_valid (rd_valid)
);

// File: tb/nand_op_seq_tb.sv
`timescale 1ns/1ps
// Bench: byte-level device model, frame log, directed corners and seeded random ops.
module nand_op_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic [11:0] req_len = '0;
    logic [7:0]  wr_data;
    logic        wr_take, rd_valid, busy, done, fail, spi_cs_n, xfer_req;
    logic [7:0]  rd_data, xfer_tx;
    logic        xfer_ack;
    logic [7:0]  xfer_rx;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    nand_op_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .fail(fail), .spi_cs_n(spi_cs_n),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    function automatic logic [7:0] pg(int c);
        return 8'((c * 13 + 5) & 255);
    endfunction
    function automatic logic [7:0] wpat(int i);
        return 8'((i * 29 + 7) & 255);
    endfunction
    function automatic int nb_of(logic [7:0] o);
        case (o)
            8'h13, 8'hD8, 8'h10: return 3;
            8'h03, 8'h84:        return 2;
            8'h0F:               return 1;
            default:             return 0;
        endcase
    endfunction

    // Host write stream and read capture.
    int widx = 0;
    int rn = 0;
    logic [7:0] rbuf [0:8191];
    assign wr_data = wpat(widx);
    always @(posedge clk) begin
        if (wr_take) widx <= widx + 1;
        if (rd_valid) begin
            rbuf[rn % 8192] <= rd_data;
            rn <= rn + 1;
        end
    end

    // Device and byte-master model with frame log.
    logic        ack_r = 1'b0;
    logic [7:0]  rx_r = '0;
    int          wcnt = 0, fidx = 0, busy_left = 0, cfg_polls = 0;
    logic [7:0]  cfg_stat = '0;
    logic        in_fr = 1'b0;
    logic [7:0]  fop = '0;
    logic [23:0] faddr = '0;
    logic [7:0]  pbuf [0:4095];
    logic [7:0]  lg_op [0:255];
    logic [23:0] lg_addr [0:255];
    int          lg_nb [0:255];
    int          lg_n = 0;
    int          gap = 0, min_gap = 999, req_no_cs = 0;
    logic        had_frame = 1'b0, prev_cs = 1'b1;
    assign xfer_ack = ack_r;
    assign xfer_rx  = rx_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0; wcnt <= 0; fidx <= 0; in_fr <= 1'b0; faddr <= '0;
        end else begin
            ack_r <= 1'b0;
            if (ack_r) begin
                if (fidx == 0) fop <= xfer_tx;
                else if (fidx <= nb_of(fop)) faddr <= {faddr[15:0], xfer_tx};
                else if (fop == 8'h84) pbuf[(fidx - 3) % 4096] <= xfer_tx;
                fidx <= fidx + 1;
            end else if (xfer_req) begin
                if (wcnt == 1) begin
                    ack_r <= 1'b1;
                    wcnt  <= 0;
                    rx_r  <= 8'h00;
                    if (fop == 8'h0F && fidx == 2) begin
                        if (busy_left > 0) begin
                            rx_r <= 8'h01;
                            busy_left <= busy_left - 1;
                        end else begin
                            rx_r <= cfg_stat;
                        end
                    end else if (fop == 8'h03 && fidx >= 4) begin
                        rx_r <= pg(int'(faddr[15:0]) + fidx - 4);
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
            if (spi_cs_n && in_fr) begin
                lg_op[lg_n % 256]   <= fop;
                lg_addr[lg_n % 256] <= faddr;
                lg_nb[lg_n % 256]   <= fidx;
                lg_n  <= lg_n + 1;
                in_fr <= 1'b0;
                fidx  <= 0;
                faddr <= '0;
                if (fop == 8'h13 || fop == 8'hD8 || fop == 8'h10) busy_left <= cfg_polls;
            end
            if (!spi_cs_n) in_fr <= 1'b1;
            prev_cs <= spi_cs_n;
            if (spi_cs_n) gap <= gap + 1;
            else begin
                if (prev_cs && had_frame && gap < min_gap) min_gap <= gap;
                gap <= 0;
                had_frame <= 1'b1;
            end
            if (xfer_req && spi_cs_n) req_no_cs <= req_no_cs + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wait_done(output logic f);
        int n = 0;
        while (done !== 1'b1) begin
            @(negedge clk);
            n++;
            if (n > 30000) begin
                chk(1'b0, "R1", "watchdog waiting for done", 0, 1);
                finish_run();
            end
        end
        f = fail;
    endtask

    task automatic exp_frame(inout int k, input logic [7:0] o, input logic [23:0] a, input int nb, input string req);
        chk(lg_op[k % 256] == o, req, "frame opcode", lg_op[k % 256], o);
        chk(lg_addr[k % 256] == a, req, "frame address", lg_addr[k % 256], a);
        chk(lg_nb[k % 256] == nb, req, "frame length", lg_nb[k % 256], nb);
        k++;
    endtask

    function automatic bit exp_fail_of(logic [1:0] op, logic [7:0] s);
        if (op == 2'd2) return s[2];
        if (op == 2'd1) return s[3];
        return s[5:4] == 2'b10;
    endfunction

    // Check the frames an op must have produced, starting at log index k.
    task automatic verify_frames(inout int k, input logic [1:0] op, input logic [23:0] row,
                                 input logic [15:0] col, input int len, input int polls, input logic [7:0] st);
        bit ef = exp_fail_of(op, st);
        if (op == 2'd0) exp_frame(k, 8'h13, row, 4, "R4");
        else begin
            exp_frame(k, 8'h06, 24'h0, 1, op == 2'd2 ? "R2" : "R5");
            if (op == 2'd2) exp_frame(k, 8'hD8, {row[23:6], 6'd0}, 4, "R2");
            else begin
                exp_frame(k, 8'h84, {8'h0, col}, 3 + len, "R5");
                exp_frame(k, 8'h10, row, 4, "R5");
            end
        end
        for (int i = 0; i <= polls; i++) exp_frame(k, 8'h0F, 24'h0000C0, 3, "R3");
        if (op == 2'd0 && !ef) exp_frame(k, 8'h03, {8'h0, col}, 4 + len, "R4");
    endtask

    task automatic issue(input logic [1:0] op, input logic [23:0] row, input logic [15:0] col, input int len);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_row = row; req_col = col; req_len = 12'(len);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [23:0] row, input logic [15:0] col,
                          input int len, input int polls, input logic [7:0] st);
        int base, rbase, wbase, k, miss;
        logic f;
        bit ef;
        cfg_polls = polls; cfg_stat = st;
        base = lg_n; rbase = rn; wbase = widx;
        ef = exp_fail_of(op, st);
        issue(op, row, col, len);
        chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
        wait_done(f);
        chk(f == ef, "R6", "fail flag at done", f, ef);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after done", busy, 0);
        chk(fail == ef, "R6", "fail held after done", fail, ef);
        k = base;
        verify_frames(k, op, row, col, len, polls, st);
        chk(lg_n == k, "R3", "frame count", lg_n - base, k - base);
        if (op == 2'd0) begin
            int expn = ef ? 0 : len;
            chk(rn - rbase == expn, ef ? "R6" : "R4", "read byte count", rn - rbase, expn);
            miss = 0;
            for (int i = 0; i < expn; i++) if (rbuf[(rbase + i) % 8192] != pg(int'(col) + i)) miss++;
            chk(miss == 0, "R4", "read data mismatches", miss, 0);
        end
        if (op == 2'd1) begin
            chk(widx - wbase == len, "R5", "host bytes taken", widx - wbase, len);
            miss = 0;
            for (int i = 0; i < len; i++) if (pbuf[i] != wpat(wbase + i)) miss++;
            chk(miss == 0, "R5", "program data mismatches", miss, 0);
        end
    endtask

    initial begin
        #(8 * 190000);
        chk(1'b0, "R1", "global watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int b0, k;
        logic f;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0 && done == 1'b0 && fail == 1'b0, "R10", "busy/done/fail in reset", {busy, done, fail}, 0);
        chk(spi_cs_n == 1'b1 && xfer_req == 1'b0, "R10", "cs_n/xfer_req in reset", {spi_cs_n, xfer_req}, 2);
        chk(wr_take == 1'b0 && rd_valid == 1'b0, "R10", "strobes in reset", {wr_take, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R10", "idle after reset", {busy, spi_cs_n}, 1);

        // R1 R8: undefined op code ignored, idle stays quiet
        b0 = lg_n;
        issue(2'd3, 24'h123456, 16'h0010, 4);
        chk(busy == 1'b0, "R1", "op 3 not accepted", busy, 0);
        repeat (6) @(negedge clk);
        chk(lg_n == b0 && spi_cs_n == 1'b1, "R8", "no frame while idle", lg_n - b0, 0);

        // Directed corners
        run_op(2'd2, 24'hABCDEF, 16'h0, 0, 2, 8'h00);     // R2 erase, row low bits cleared
        run_op(2'd2, 24'h00007F, 16'h0, 0, 0, 8'h04);     // R6 erase fail bit
        run_op(2'd1, 24'h000200, 16'h0000, 8, 1, 8'h30);  // R6 program pass despite ECC bits
        run_op(2'd1, 24'h000201, 16'h0830, 5, 3, 8'h08);  // R6 program fail
        run_op(2'd0, 24'h000040, 16'h0000, 16, 1, 8'h0C); // R6 read pass despite erase/program bits
        run_op(2'd0, 24'h000041, 16'h0020, 16, 2, 8'h20); // R6 read ECC uncorrectable, no cache read
        b0 = lg_n;
        run_op(2'd0, 24'h000042, 16'h083F, 0, 0, 8'h00);  // R11 zero-length read
        chk(lg_nb[(b0 + 2) % 256] == 4, "R11", "zero-length read frame", lg_nb[(b0 + 2) % 256], 4);
        b0 = lg_n;
        run_op(2'd1, 24'h000043, 16'h0005, 0, 0, 8'h00);  // R11 zero-length program
        chk(lg_nb[(b0 + 1) % 256] == 3, "R11", "zero-length program frame", lg_nb[(b0 + 1) % 256], 3);
        run_op(2'd0, 24'h0000C0, 16'h0000, 2112, 0, 8'h10); // R4 full page with spare area

        // R9: request during busy ignored, held across done accepted once
        cfg_polls = 1; cfg_stat = 8'h00;
        b0 = lg_n;
        issue(2'd2, 24'h001234, 16'h0, 0);
        req_valid = 1'b1; req_op = 2'd1; req_row = 24'h000777; req_col = 16'h0100; req_len = 12'd3;
        wait_done(f);
        @(negedge clk);
        chk(busy == 1'b0, "R9", "busy low after done with held request", busy, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9", "held request accepted", busy, 1);
        wait_done(f);
        @(negedge clk);
        k = b0;
        verify_frames(k, 2'd2, 24'h001234, 16'h0, 0, 1, 8'h00);
        verify_frames(k, 2'd1, 24'h000777, 16'h0100, 3, 1, 8'h00);
        repeat (4) @(negedge clk);
        chk(lg_n == k && busy == 1'b0, "R9", "held request taken only once", lg_n - b0, k - b0);

        // Seeded random mix
        for (int n = 0; n < 30; n++) begin
            logic [1:0] op = 2'($urandom_range(0, 2));
            logic [7:0] st = 8'($urandom) & 8'hFE;
            run_op(op, 24'($urandom), 16'($urandom_range(0, 2111)), $urandom_range(0, 40),
                   $urandom_range(0, 4), st);
        end

        // R7 framing over the whole run
        chk(min_gap >= 1, "R7", "minimum deselect gap", min_gap, 1);
        chk(req_no_cs == 0, "R7", "byte requests without chip select", req_no_cs, 0);
        finish_run();
    end
endmodule